// File: doc/BRIEF.md
# BIST Frame Launch Control Register

This block is a control and status register through which software starts a built-in-self-test frame on one of two serial storage ports, and then learns how that frame ended. Software sets a shared six-bit parameter field and two data words. It then writes a 1 to a per-port initiate bit. A 0-to-1 change of that stored bit asks for a launch. The request is honoured only when the target port is eligible and no other frame is in flight. An eligible port has a device present and ready, and is not locked.

An honoured request is handed to a link-layer stub over a valid/ready handshake. The block then waits for a one-cycle completion pulse carrying a good/error status. A good completion sets a success flag and locks that port until its enable input falls and rises again. An error completion sets a failure flag. Software can retry after an error by clearing and then setting the initiate bit. Both flags are cleared by writing a 1 to them.

The register bus is a simple word-addressed write strobe with a combinational read. Word 0 is the control register. Word 1 holds data word 0 and word 2 holds data word 1.

Top module: `bist_launch_ctrl`

## Requirements
- R1: After reset, all three registers read 0 and launch_valid_o is low.
- R2: In the control word, bits 31:12 and 1:0 read as 0 and ignore writes. Bits 7:2 are a read/write parameter field. Words 1 and 2 are full 32-bit read/write data registers. Word 3 reads 0.
- R3: Bit 8 (port 0) and bit 9 (port 1) are read/write initiate bits. A launch is requested only when a control write changes the stored bit from 0 to 1. Writing 1 over a stored 1 requests nothing.
- R4: A request for a port whose present or ready input is low is dropped. It is not queued, and it does not launch when the port later becomes ready.
- R5: In the cycle after an honoured control write, launch_valid_o rises. It stays high with a stable payload until launch_ready_i is seen high. The payload is the port number, pattern byte {bits 7:2, 2'b00} and the two data words, all as they were at the write. Later register writes do not change it.
- R6: Only one frame is outstanding, from launch until its completion. Requests made during that time are dropped. When both ports rise in one write, port 0 is launched and port 1 is dropped.
- R7: A done_i pulse is accepted only after the handshake and before completion. With done_err_i low it sets bit 11, and with done_err_i high it sets bit 10. A done_i pulse at any other time has no effect.
- R8: Writing 1 to bit 11 or bit 10 clears that flag, and writing 0 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R9: A good completion locks that port, and its requests are dropped until port_en_i for the port goes low and then high. After an error the port is not locked, and clearing then setting the initiate bit launches again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the addressed word |
| port_present_i | input | 2 | Device present, one bit per port |
| port_ready_i | input | 2 | Device ready (not in a low-power state), per port |
| port_en_i | input | 2 | Port enable, per port |
| launch_valid_o | output | 1 | Launch request valid |
| launch_ready_i | input | 1 | Link stub accepts the launch |
| launch_port_o | output | 1 | Target port of the launch |
| launch_pattern_o | output | 8 | Pattern-definition byte |
| launch_data0_o | output | 32 | First data word |
| launch_data1_o | output | 32 | Second data word |
| done_i | input | 1 | Completion pulse |
| done_err_i | input | 1 | Completion status, 1 = error |

## Verification
Two pairs of events can land in the same cycle. The first pair is a completion setting a flag and a software write clearing that same flag. The second pair is an initiate edge arriving while a frame is outstanding, or on both ports at once. The bench provokes the first by driving done_i on the exact cycle of a write-one-to-clear, and expects the flag to read back set. It provokes the second by writing the other port's initiate bit while launch_ready_i is held low, and by raising both bits in one write. In both cases it expects the payload to stay on port 0 and no later launch to appear. A behavioural reference model, stepped every clock, checks all of these outcomes.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} launch_st_e;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_D0   = 1;
  localparam int ADDR_D1   = 2;

  localparam int OK_BIT    = 11;
  localparam int ERR_BIT   = 10;
  localparam int INIT_LSB  = 8;
  localparam int PAR_LSB   = 2;
  localparam int PAR_W     = 6;
  localparam int PAT_W     = 8;
endpackage

// File: rtl/bist_port_lock.sv
module bist_port_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic present_i,
  input  logic ready_i,
  input  logic en_i,
  input  logic lock_set_i,
  output logic elig_o
);
  logic en_q, lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      en_q <= en_i;
      if (lock_set_i)           lock_q <= 1'b1;
      else if (en_i && !en_q)   lock_q <= 1'b0;  // release on enable re-assert
    end
  end

  assign elig_o = present_i && ready_i && !lock_q;

  a_r9_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_set_i |=> !elig_o);
endmodule

// File: rtl/bist_launch_fsm.sv
module bist_launch_fsm
  import bist_pkg::*;
#(
  parameter int DW     = 32,
  parameter int PORT_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PORT_W-1:0] start_port_i,
  input  logic [PAT_W-1:0]  start_pat_i,
  input  logic [DW-1:0]     start_d0_i,
  input  logic [DW-1:0]     start_d1_i,
  input  logic              launch_ready_i,
  input  logic              done_i,
  input  logic              done_err_i,
  output logic              idle_o,
  output logic              launch_valid_o,
  output logic [PORT_W-1:0] launch_port_o,
  output logic [PAT_W-1:0]  launch_pattern_o,
  output logic [DW-1:0]     launch_data0_o,
  output logic [DW-1:0]     launch_data1_o,
  output logic              ok_pulse_o,
  output logic              err_pulse_o
);
  launch_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q             <= ST_IDLE;
      launch_port_o    <= '0;
      launch_pattern_o <= '0;
      launch_data0_o   <= '0;
      launch_data1_o   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q             <= ST_REQ;
          launch_port_o    <= start_port_i;
          launch_pattern_o <= start_pat_i;
          launch_data0_o   <= start_d0_i;
          launch_data1_o   <= start_d1_i;
        end
        ST_REQ:  if (launch_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (done_i)         st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o         = (st_q == ST_IDLE);
  assign launch_valid_o = (st_q == ST_REQ);
  assign ok_pulse_o     = (st_q == ST_WAIT) && done_i && !done_err_i;
  assign err_pulse_o    = (st_q == ST_WAIT) && done_i &&  done_err_i;

  a_r5_hold_payload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_valid_o && !launch_ready_i) |=>
      (launch_valid_o && $stable(launch_port_o) && $stable(launch_pattern_o)
       && $stable(launch_data0_o) && $stable(launch_data1_o)));

  a_r6_drop_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !idle_o) |=> ($stable(launch_port_o) && $stable(launch_data0_o)));
endmodule

// File: rtl/bist_launch_ctrl.sv
module bist_launch_ctrl
  import bist_pkg::*;
#(
  parameter int NPORT = 2,
  parameter int DW    = 32,
  parameter int AW    = 2,
  localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic [NPORT-1:0]  port_present_i,
  input  logic [NPORT-1:0]  port_ready_i,
  input  logic [NPORT-1:0]  port_en_i,
  output logic              launch_valid_o,
  input  logic              launch_ready_i,
  output logic [PORT_W-1:0] launch_port_o,
  output logic [PAT_W-1:0]  launch_pattern_o,
  output logic [DW-1:0]     launch_data0_o,
  output logic [DW-1:0]     launch_data1_o,
  input  logic              done_i,
  input  logic              done_err_i
);
  logic [NPORT-1:0] init_q, rise, elig, lock_set;
  logic [PAR_W-1:0] par_q;
  logic [DW-1:0]    d0_q, d1_q;
  logic             ok_q, err_q;
  logic             ctrl_wr, start;
  logic [PORT_W-1:0] start_port;
  logic             idle, ok_pulse, err_pulse;

  assign ctrl_wr = reg_we_i && (reg_addr_i == AW'(ADDR_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      par_q  <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        init_q <= reg_wdata_i[INIT_LSB +: NPORT];
        par_q  <= reg_wdata_i[PAR_LSB +: PAR_W];
      end
      if (reg_we_i && reg_addr_i == AW'(ADDR_D0)) d0_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == AW'(ADDR_D1)) d1_q <= reg_wdata_i;
      // hardware set wins over write-one-to-clear
      ok_q  <= ok_pulse  || (ok_q  && !(ctrl_wr && reg_wdata_i[OK_BIT]));
      err_q <= err_pulse || (err_q && !(ctrl_wr && reg_wdata_i[ERR_BIT]));
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign rise[p]     = ctrl_wr && reg_wdata_i[INIT_LSB+p] && !init_q[p];
    assign lock_set[p] = ok_pulse && (launch_port_o == PORT_W'(p));
    bist_port_lock u_lock (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .present_i  (port_present_i[p]),
      .ready_i    (port_ready_i[p]),
      .en_i       (port_en_i[p]),
      .lock_set_i (lock_set[p]),
      .elig_o     (elig[p])
    );
  end

  // lowest eligible rising port
  always_comb begin
    start      = 1'b0;
    start_port = '0;
    for (int p = NPORT-1; p >= 0; p--) begin
      if (rise[p] && elig[p]) begin
        start      = 1'b1;
        start_port = PORT_W'(p);
      end
    end
  end

  bist_launch_fsm #(.DW(DW), .PORT_W(PORT_W)) u_fsm (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .start_i          (start),
    .start_port_i     (start_port),
    .start_pat_i      ({par_q, 2'b00}),
    .start_d0_i       (d0_q),
    .start_d1_i       (d1_q),
    .launch_ready_i   (launch_ready_i),
    .done_i           (done_i),
    .done_err_i       (done_err_i),
    .idle_o           (idle),
    .launch_valid_o   (launch_valid_o),
    .launch_port_o    (launch_port_o),
    .launch_pattern_o (launch_pattern_o),
    .launch_data0_o   (launch_data0_o),
    .launch_data1_o   (launch_data1_o),
    .ok_pulse_o       (ok_pulse),
    .err_pulse_o      (err_pulse)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      AW'(ADDR_CTRL): begin
        reg_rdata_o[OK_BIT]               = ok_q;
        reg_rdata_o[ERR_BIT]              = err_q;
        reg_rdata_o[INIT_LSB +: NPORT]    = init_q;
        reg_rdata_o[PAR_LSB +: PAR_W]     = par_q;
      end
      AW'(ADDR_D0): reg_rdata_o = d0_q;
      AW'(ADDR_D1): reg_rdata_o = d1_q;
      default:      reg_rdata_o = '0;
    endcase
  end

  a_r3_launch_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(launch_valid_o) |-> $past(ctrl_wr && (|rise)));

  a_r7_ok_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_pulse |=> ok_q);

  a_r8_err_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_pulse && ctrl_wr && reg_wdata_i[ERR_BIT]) |=> err_q);

  a_r6_idle_when_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_valid_o |-> !idle);
endmodule

// File: tb/bist_launch_ctrl_test.sv
module bist_launch_ctrl_test;
  localparam time T = 20ns;

  logic        clk = 0, rst_n = 0;
  logic        we = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [1:0]  present = 2'b11, ready = 2'b11, en = 2'b11;
  logic        lvalid, lready = 1;
  logic        lport;
  logic [7:0]  lpat;
  logic [31:0] ld0, ld1;
  logic        done = 0, derr = 0;

  always #(T/2) clk = ~clk;

  bist_launch_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .port_present_i(present),
    .port_ready_i(ready), .port_en_i(en), .launch_valid_o(lvalid),
    .launch_ready_i(lready), .launch_port_o(lport), .launch_pattern_o(lpat),
    .launch_data0_o(ld0), .launch_data1_o(ld1), .done_i(done), .done_err_i(derr)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // behavioural reference model
  bit [1:0]  m_init, m_lock, m_enq;
  bit [5:0]  m_par;
  bit        m_ok, m_err;
  bit [31:0] m_d0, m_d1, m_pd0, m_pd1;
  int        m_state;  // 0 idle, 1 requesting, 2 waiting
  int        m_port;
  bit [7:0]  m_pat;

  function automatic bit [31:0] m_read(input bit [1:0] a);
    case (a)
      2'd0: return {20'd0, m_ok, m_err, m_init, m_par, 2'b00};
      2'd1: return m_d0;
      2'd2: return m_d1;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_init = 0; m_lock = 0; m_enq = 0; m_par = 0; m_ok = 0; m_err = 0;
      m_d0 = 0; m_d1 = 0; m_pd0 = 0; m_pd1 = 0; m_state = 0; m_port = 0; m_pat = 0;
    end else begin
      bit cw, acc, good;
      int sel;
      cw   = we && addr == 2'd0;
      acc  = (m_state == 2) && done;
      good = acc && !derr;
      sel  = -1;
      for (int p = 1; p >= 0; p--)
        if (cw && wdata[8+p] && !m_init[p] && present[p] && ready[p] && !m_lock[p]) sel = p;
      m_ok  = good || (m_ok && !(cw && wdata[11]));
      m_err = (acc && derr) || (m_err && !(cw && wdata[10]));
      for (int p = 0; p < 2; p++) begin
        if (good && m_port == p) m_lock[p] = 1;
        else if (en[p] && !m_enq[p]) m_lock[p] = 0;
      end
      m_enq = en;
      case (m_state)
        0: if (sel >= 0) begin
          m_state = 1; m_port = sel; m_pat = {m_par, 2'b00}; m_pd0 = m_d0; m_pd1 = m_d1;
        end
        1: if (lready) m_state = 2;
        2: if (done) m_state = 0;
        default: m_state = 0;
      endcase
      if (cw) begin m_init = wdata[9:8]; m_par = wdata[7:2]; end
      if (we && addr == 2'd1) m_d0 = wdata;
      if (we && addr == 2'd2) m_d1 = wdata;
      #(T/4);
      check(cur_req, rdata, m_read(addr));
      check(cur_req, {31'd0, lvalid}, {31'd0, m_state == 1});
      if (m_state == 1)
        check(cur_req, {lport, lpat, ld0[22:0]}, {m_port[0], m_pat, m_pd0[22:0]});
      if (m_state == 1) check(cur_req, ld1, m_pd1);
    end
  end

  task automatic wr(input bit [1:0] a, input bit [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; addr = 0; wdata = 0;
    #1;
  endtask

  task automatic pulse_done(input bit e);
    @(negedge clk); done = 1; derr = e;
    @(negedge clk); done = 0; derr = 0;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic peek(input string req, input bit [1:0] a, input bit [31:0] exp);
    @(negedge clk); addr = a; #1;
    check(req, rdata, exp);
    addr = 0;
  endtask

  bit finished = 0;

  initial begin
    #(T*100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(T*3); rst_n = 1;
    // R1
    cur_req = "R1";
    #1; check("R1", rdata, 0); check("R1", {31'd0, lvalid}, 0);
    peek("R1", 1, 0); peek("R1", 2, 0);

    // R2 reserved bits and data registers
    cur_req = "R2";
    wr(0, 32'hFFFF_F0FF);
    check("R2", rdata, 32'h0000_00FC);
    wr(1, 32'hA5A5_0001); wr(2, 32'h5A5A_F00E);
    peek("R2", 1, 32'hA5A5_0001); peek("R2", 2, 32'h5A5A_F00E); peek("R2", 3, 0);

    // R5 launch payload held until ready
    cur_req = "R5";
    lready = 0;
    wr(0, 32'h1FC);
    check("R5", {lvalid, lport, lpat}, {1'b1, 1'b0, 8'hFC});
    check("R5", ld0, 32'hA5A5_0001);
    wr(2, 32'h0);
    idle(3);
    check("R5", {31'd0, lvalid}, 1);
    check("R5", ld1, 32'h5A5A_F00E);
    lready = 1; idle(1);
    check("R5", {31'd0, lvalid}, 0);

    // R7 error completion
    cur_req = "R7";
    pulse_done(1);
    check("R7", rdata, 32'h5FC);

    // R3 level does not relaunch
    cur_req = "R3";
    wr(0, 32'h1FC);
    check("R3", {31'd0, lvalid}, 0);

    // R9 retry after error
    cur_req = "R9";
    wr(0, 32'h0FC); wr(0, 32'h1FC);
    check("R9", {31'd0, lvalid}, 1);
    idle(1);
    pulse_done(0);
    check("R7", rdata, 32'hDFC);

    // R8 clear error flag only
    cur_req = "R8";
    wr(0, 32'h5FC);
    check("R8", rdata, 32'h9FC);

    // R9 lock after success, release by enable toggle
    cur_req = "R9";
    wr(0, 32'h0FC); wr(0, 32'h1FC);
    check("R9", {31'd0, lvalid}, 0);
    @(negedge clk); en = 2'b10; @(negedge clk); en = 2'b11;
    wr(0, 32'h0FC); wr(0, 32'h1FC);
    check("R9", {lvalid, lport}, 2'b10);
    idle(1); pulse_done(1);

    // R4 ineligible request dropped, not queued
    cur_req = "R4";
    ready = 2'b01;
    wr(0, 32'h2FC);
    check("R4", {31'd0, lvalid}, 0);
    @(negedge clk); ready = 2'b11;
    idle(3);
    check("R4", {31'd0, lvalid}, 0);
    wr(0, 32'h2FC);
    check("R4", {31'd0, lvalid}, 0);
    wr(0, 32'h0FC); wr(0, 32'h2FC);
    check("R4", {lvalid, lport}, 2'b11);
    idle(1); pulse_done(1);

    // R6 one outstanding, port 0 priority
    cur_req = "R6";
    lready = 0;
    wr(0, 32'h0FC); wr(0, 32'h1FC); wr(0, 32'h3FC);
    check("R6", {lvalid, lport}, 2'b10);
    lready = 1; idle(1); pulse_done(1);
    idle(2);
    check("R6", {31'd0, lvalid}, 0);
    wr(0, 32'h0FC); wr(0, 32'h3FC);
    check("R6", {lvalid, lport}, 2'b10);
    idle(1); pulse_done(1);

    // R7 done while idle ignored
    cur_req = "R7";
    wr(0, 32'hCFC);
    check("R8", rdata, 32'h0FC);
    pulse_done(0);
    check("R7", rdata, 32'h0FC);

    // R8 set wins over same-cycle clear
    cur_req = "R8";
    wr(0, 32'h1FC);
    idle(1);
    @(negedge clk); done = 1; derr = 0; we = 1; addr = 0; wdata = 32'h9FC;
    @(negedge clk); done = 0; we = 0; wdata = 0; #1;
    check("R8", rdata, 32'h9FC);
    wr(0, 32'h9FC);
    check("R8", rdata, 32'h1FC);

    idle(2);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule